// File: doc/BRIEF.md
# Right-Only Barrel Shifter With Pre-Extension

This block is a purely combinational 32-bit shifter. It performs logical left, logical right, arithmetic right and rotate right, and all four share a single cascade of right-shifting multiplexer stages. Before shifting, the operand is widened to 63 bits. The upper 31 bits are chosen so that whatever shifts into the kept window is correct for the selected operation: zeros, copies of the sign, or the operand's own low bits.

A left shift is mapped onto the same right-shift hardware. The operand is placed in the upper half of the widened word, and the five amount bits are inverted before they steer the stages. Shifting left by k is therefore carried out as shifting right by 31-k. Each of the five stages either passes its input or moves it right by 16, 8, 4, 2 or 1 positions. Each stage drops the bits it can no longer need, so the final stage is exactly 32 bits wide. The block is meant to sit inside an ALU as its shift unit. A rotate left is not provided; the caller expresses it as a rotate right by the complementary amount.

Top module: `xrs_shifter`

## Requirements
- R1: shiftOp code 2'b00 selects logical left shift: result equals dataIn shifted left by shiftAmt, with zeros filling the vacated low bits.
- R2: shiftOp code 2'b10 selects logical right shift: result equals dataIn shifted right by shiftAmt, with zeros filling the vacated high bits.
- R3: shiftOp code 2'b01 selects arithmetic right shift: vacated high bits are copies of dataIn[31], so result[31] always equals dataIn[31].
- R4: shiftOp code 2'b11 selects rotate right: bit i of result equals dataIn[(i + shiftAmt) mod 32], and no bit is lost or invented.
- R5: With shiftAmt = 0, result equals dataIn for every one of the four operation codes.
- R6: With shiftAmt = 31, logical left gives {dataIn[0], 31 zeros}, logical right gives dataIn[31] in bit 0 with all other bits zero, and arithmetic right gives 32 copies of dataIn[31].
- R7: result depends only on the present inputs: a change of any input is reflected at result without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 32 | Operand to be shifted or rotated |
| shiftAmt | input | 5 | Shift or rotate distance, 0 to 31 |
| shiftOp | input | 2 | Operation code: 00 left logical, 01 right arithmetic, 10 right logical, 11 rotate right |
| result | output | 32 | Shifted or rotated operand |

## Verification
The block holds no state, so a wrong internal value appears at result in the same evaluation in which the inputs change; no later cycle can hide it or reveal it. Each mux stage is active only when its amount bit is set. A broken stage, a wrong fill choice, or a missing amount inversion for left shifts therefore shows only for some amounts. For that reason all 32 amounts are swept against every operation code with several operand patterns, including patterns whose sign bit is set and patterns whose sign bit is clear. Amount 0 and amount 31 are checked separately, because at those two amounts the left-shift inversion drives the stage cascade to its opposite extreme.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRA = 2'b01,
    OP_SRL = 2'b10,
    OP_ROR = 2'b11
  } shiftOp_e;

  // One-hot strobes from control to datapath
  typedef struct packed {
    logic leftMode;   // operand in upper half, amount inverted
    logic signFill;   // upper extension = sign copies
    logic wrapFill;   // upper extension = low operand bits
    logic zeroFill;   // upper extension = zeros
  } shiftStrobes_t;

endpackage

// File: rtl/xrs_ctrl.sv
module xrs_ctrl
  import xrs_pkg::*;
(
  input  logic [1:0]    shiftOp,
  output shiftStrobes_t strobes
);

  shiftOp_e opDec;

  always_comb begin
    opDec   = shiftOp_e'(shiftOp);
    strobes = '0;
    unique case (opDec)
      OP_SLL:  strobes.leftMode = 1'b1;
      OP_SRA:  strobes.signFill = 1'b1;
      OP_SRL:  strobes.zeroFill = 1'b1;
      OP_ROR:  strobes.wrapFill = 1'b1;
      default: strobes.zeroFill = 1'b1;
    endcase
  end

  // R1..R4: exactly one widening mode is active per operation
  always_comb begin
    if (!$isunknown(shiftOp)) begin
      a_r1_single_mode: assert ($onehot(strobes))
        else $error("strobes not one-hot");
    end
  end

endmodule

// File: rtl/xrs_extend.sv
module xrs_extend
  import xrs_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SA_W  = $clog2(DATA_W),
  localparam int EXT_W = 2 * DATA_W - 1
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [SA_W-1:0]   shiftAmt,
  input  shiftStrobes_t     strobes,
  output logic [EXT_W-1:0]  extData,
  output logic [SA_W-1:0]   effAmt
);

  logic [DATA_W-2:0] upperFill;

  always_comb begin
    upperFill = '0;
    if (strobes.signFill) upperFill = {(DATA_W-1){dataIn[DATA_W-1]}};
    if (strobes.wrapFill) upperFill = dataIn[DATA_W-2:0];

    if (strobes.leftMode) begin
      extData = {dataIn, {(DATA_W-1){1'b0}}};
      effAmt  = ~shiftAmt;
    end else begin
      extData = {upperFill, dataIn};
      effAmt  = shiftAmt;
    end
  end

endmodule

// File: rtl/xrs_stages.sv
module xrs_stages #(
  parameter int DATA_W = 32,
  localparam int SA_W  = $clog2(DATA_W),
  localparam int EXT_W = 2 * DATA_W - 1
) (
  input  logic [EXT_W-1:0]  extData,
  input  logic [SA_W-1:0]   effAmt,
  output logic [DATA_W-1:0] result
);

  // Stage i applies amount bit SA_W-1-i; widths shrink by each distance
  for (genvar i = 0; i < SA_W; i++) begin : g_stage
    localparam int DIST  = 1 << (SA_W - 1 - i);
    localparam int IN_W  = EXT_W - ((1 << SA_W) - (1 << (SA_W - i)));
    localparam int OUT_W = IN_W - DIST;

    logic [IN_W-1:0]  stageIn;
    logic [OUT_W-1:0] stageOut;

    if (i == 0) begin : g_first
      assign stageIn = extData;
    end else begin : g_next
      assign stageIn = g_stage[i-1].stageOut;
    end

    assign stageOut = effAmt[SA_W-1-i] ? stageIn[IN_W-1:DIST]
                                       : stageIn[OUT_W-1:0];
  end

  assign result = g_stage[SA_W-1].stageOut;

endmodule

// File: rtl/xrs_shifter.sv
module xrs_shifter
  import xrs_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SA_W  = $clog2(DATA_W),
  localparam int EXT_W = 2 * DATA_W - 1
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [SA_W-1:0]   shiftAmt,
  input  logic [1:0]        shiftOp,
  output logic [DATA_W-1:0] result
);

  shiftStrobes_t     strobes;
  logic [EXT_W-1:0]  extData;
  logic [SA_W-1:0]   effAmt;

  xrs_ctrl u_ctrl (
    .shiftOp (shiftOp),
    .strobes (strobes)
  );

  xrs_extend #(.DATA_W(DATA_W)) u_extend (
    .dataIn   (dataIn),
    .shiftAmt (shiftAmt),
    .strobes  (strobes),
    .extData  (extData),
    .effAmt   (effAmt)
  );

  xrs_stages #(.DATA_W(DATA_W)) u_stages (
    .extData (extData),
    .effAmt  (effAmt),
    .result  (result)
  );

  always_comb begin
    if (!$isunknown({dataIn, shiftAmt, shiftOp})) begin
      // R5
      if (shiftAmt == '0)
        a_r5_zero_amount: assert (result == dataIn) else $error("amt 0 altered data");
      // R2
      if (shiftOp == 2'b10 && shiftAmt != '0)
        a_r2_srl_top_clear: assert (result[DATA_W-1] == 1'b0) else $error("srl top bit set");
      // R3
      if (shiftOp == 2'b01)
        a_r3_sra_sign_kept: assert (result[DATA_W-1] == dataIn[DATA_W-1]) else $error("sra sign lost");
      // R1
      if (shiftOp == 2'b00 && shiftAmt != '0)
        a_r1_sll_low_clear: assert (result[0] == 1'b0) else $error("sll low bit set");
      // R4
      if (shiftOp == 2'b11)
        a_r4_ror_bits_kept: assert ($countones(result) == $countones(dataIn)) else $error("ror popcount");
    end
  end

endmodule

// File: tb/xrs_shifter_bench.sv
module xrs_shifter_bench;

  logic        clk = 1'b0;
  logic [31:0] dataIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic [1:0]  shiftOp = '0;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  xrs_shifter u_xrs_shifter (
    .dataIn   (dataIn),
    .shiftAmt (shiftAmt),
    .shiftOp  (shiftOp),
    .result   (result)
  );

  function automatic logic [31:0] model(input logic [31:0] d, input logic [4:0] a,
                                        input logic [1:0] op);
    logic [63:0] dbl;
    dbl = {d, d} >> a;
    case (op)
      2'b00:   return d << a;
      2'b10:   return d >> a;
      2'b01:   return 32'($signed(d) >>> a);
      default: return dbl[31:0];
    endcase
  endfunction

  task automatic apply(input logic [31:0] d, input logic [4:0] a, input logic [1:0] op);
    @(negedge clk);
    dataIn = d; shiftAmt = a; shiftOp = op;
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s op=%b amt=%0d data=%h actual=%h expected=%h",
               tag, shiftOp, shiftAmt, dataIn, result, exp);
    end
  endtask

  function automatic string opTag(input logic [1:0] op);
    case (op)
      2'b00:   return "R1";
      2'b10:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [31:0] pat [8];
    logic [31:0] lf;
    pat[0] = 32'h0000_0001; pat[1] = 32'h8000_0000;
    pat[2] = 32'hFFFF_FFFF; pat[3] = 32'h7FFF_FFFF;
    pat[4] = 32'hA5C3_0F96;
    lf = 32'h1234_5678;
    for (int k = 5; k < 8; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} * 32'd2654435761 + 32'd7;
      pat[k] = lf;
    end

    // R7: all-zero inputs settle to zero with no clock involvement
    apply(32'h0, 5'd0, 2'b00);
    check("R7", 32'h0);

    // R1..R4 sweep: every op, every amount, several operands
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 8; p++) begin
          apply(pat[p], 5'(a), 2'(op));
          check(opTag(2'(op)), model(pat[p], 5'(a), 2'(op)));
        end

    // R5: zero amount leaves the operand untouched
    for (int op = 0; op < 4; op++) begin
      apply(32'hDEAD_BEEF, 5'd0, 2'(op));
      check("R5", 32'hDEAD_BEEF);
    end

    // R6: extreme amount 31
    apply(32'h0000_0003, 5'd31, 2'b00); check("R6", 32'h8000_0000);
    apply(32'hC000_0000, 5'd31, 2'b10); check("R6", 32'h0000_0001);
    apply(32'h8000_0001, 5'd31, 2'b01); check("R6", 32'hFFFF_FFFF);
    apply(32'h7FFF_FFFF, 5'd31, 2'b01); check("R6", 32'h0000_0000);

    // R7: input change visible within the same low clock phase
    apply(32'h0000_00F0, 5'd4, 2'b10);
    check("R7", 32'h0000_000F);
    dataIn = 32'h0000_0F00; #1;
    check("R7", 32'h0000_00F0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule